// File: doc/BRIEF.md
# Sticky Interrupt Source Controller

This block gathers one-cycle event pulses from ten independent subsystems and turns them into a single level interrupt for the host. Each pulse is caught in its own sticky source bit. The bit stays set until the host reads the source register, and that read clears every source bit at once. An enable register with the same bit layout selects which pending sources may raise the interrupt line.

The host reaches both registers through a small read/write port. Both strobes last one cycle. Read data is combinational and valid in the same cycle as the read strobe. The source register also carries a debug flag in bit 31. This flag is set when any source pulses again while its bit is still pending and the host has not yet read the register.

Each source bit is held by a two-state machine. `SRC_IDLE` moves to `SRC_PEND` on a pulse. `SRC_PEND` moves back to `SRC_IDLE` on a clear strobe that has no pulse in the same cycle. `SRC_PEND` stays in `SRC_PEND` on a clear that coincides with a pulse, and also when no clear arrives. `SRC_IDLE` stays in `SRC_IDLE` when there is no pulse. A pulse seen while the machine is in `SRC_PEND` with no clear is a repeat hit, and a repeat hit sets the debug flag.

Top module: `intc_sticky_top`

## Requirements
- R1: After reset the source register reads 0, the enable register reads 0 and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets source bit i from the following cycle. The bit assignments, from bit 9 down to bit 0, are:
  - bit 9: DMA completion
  - bit 8: DMA error
  - bit 7: carrier over-temperature
  - bit 6: mezzanine over-temperature
  - bit 5: input over-range
  - bit 4: ADC trigger
  - bit 3: acquisition shot taken
  - bit 2: ID-bus transfer done
  - bit 1: clock-synth-bus transfer done
  - bit 0: ADC-config transfer done
- R3: A read of the source register (address 0) clears all source bits and bit 31 from the next cycle on.
- R4: A read of the source register returns the value held before the read. A pulse in the same cycle as that read leaves its bit pending after the read.
- R5: Bit 31 of the source register is set when a source pulses while its bit is already pending and no read of the source register occurs in that cycle.
- R6: `irq` is high exactly while the ten source bits ANDed with the ten enable bits are nonzero.
- R7: The enable register (address 1) can be written and read back. Write data bits 9..0 are stored, and bits 31..10 read as zero.
- R8: A write to the source register address has no effect on the source bits, the enable bits or `irq`.
- R9: Bit 31 cannot be enabled and never raises `irq`. Source-register bits 30..10 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 10 | One-cycle event pulses, one per source |
| reg_addr | input | 2 | Register address: 0 = source, 1 = enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears the sources |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high, zero otherwise |
| irq | output | 1 | Combined interrupt, active high |

## Verification
Suppose one source machine is stuck in `SRC_IDLE`. Its bit is then missing from the very next source read, and `irq` stays low one cycle after an enabled pulse. A machine that fails to leave `SRC_PEND` makes the second of two back-to-back reads non-zero. A clear that takes effect in the wrong cycle can lose a pulse that arrives during the read, and the read after that shows it. A wrong repeat decision appears as bit 31 set or missing on the next read.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC = 10;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int OVF_BIT = 31;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_t;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pending,
    output logic rep_hit
);
    src_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (evt) state_d = SRC_PEND;
            SRC_PEND: if (clr && !evt) state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == SRC_PEND);
        rep_hit = (state_q == SRC_PEND) && evt && !clr;
    end

    // R2: a pulse always leaves the cell pending
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pending);
    // R3: a clear without a pulse empties the cell
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !pending);
endmodule

// File: rtl/intc_regport.sv
module intc_regport
    import intc_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int OVB = OVF_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    input  logic [N-1:0]  pend_vec,
    input  logic          ovf,
    output logic [DW-1:0] reg_rdata,
    output logic [N-1:0]  en_vec,
    output logic          src_clr
);
    localparam logic [AW-1:0] SRC_ADDR = AW'(0);
    localparam logic [AW-1:0] EN_ADDR  = AW'(1);

    logic [N-1:0]  en_q;
    logic [DW-1:0] src_word, en_word;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata[DW-1:N];

    always_ff @(posedge clk) begin
        if (!rst_n)                            en_q <= '0;
        else if (reg_wr && reg_addr == EN_ADDR) en_q <= reg_wdata[N-1:0];
    end

    always_comb begin
        src_word           = '0;
        src_word[N-1:0]    = pend_vec;
        src_word[OVB]      = ovf;
        en_word            = '0;
        en_word[N-1:0]     = en_q;
        reg_rdata          = '0;
        if (reg_rd) begin
            if (reg_addr == SRC_ADDR)     reg_rdata = src_word;
            else if (reg_addr == EN_ADDR) reg_rdata = en_word;
        end
        src_clr = reg_rd && (reg_addr == SRC_ADDR);
        en_vec  = en_q;
    end

    // R8: writes to the source address leave the enable bits alone
    a_r8_src_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SRC_ADDR) |=> $stable(en_q));
    // R7: an enable write stores the low data bits
    a_r7_enable_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_ADDR) |=> (en_q == $past(reg_wdata[N-1:0])));
endmodule

// File: rtl/intc_sticky_top.sv
module intc_sticky_top
    import intc_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int OVB = OVF_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_pulse,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic [N-1:0] pend_vec, rep_vec, en_vec;
    logic         src_clr, ovf_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        intc_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pulse[i]),
            .clr     (src_clr),
            .pending (pend_vec[i]),
            .rep_hit (rep_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (|rep_vec) ovf_q <= 1'b1;
        else if (src_clr)  ovf_q <= 1'b0;
    end

    intc_regport #(.N(N), .DW(DW), .AW(AW), .OVB(OVB)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .pend_vec  (pend_vec),
        .ovf       (ovf_q),
        .reg_rdata (reg_rdata),
        .en_vec    (en_vec),
        .src_clr   (src_clr)
    );

    assign irq = |(pend_vec & en_vec);

    // R5: a repeat hit raises the debug flag
    a_r5_repeat_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|rep_vec) |=> ovf_q);
    // R3: a read with no repeat hit drops the debug flag
    a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr && !(|rep_vec)) |=> !ovf_q);
    // R9: the debug flag alone never raises the interrupt
    a_r9_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq);
endmodule

// File: tb/sim_intc_sticky_top.sv
module sim_intc_sticky_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_pulse = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    intc_sticky_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (reg_rd && rst_n) begin
            logic [31:0] e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: act=%h exp=none", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: act=%h exp=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic chk_irq(input logic exp, input string t);
        @(negedge clk);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq: act=%b exp=%b", t, irq, exp);
        end
    endtask

    task automatic pulse(input logic [9:0] m);
        @(posedge clk); #1 evt_pulse = m;
        @(posedge clk); #1 evt_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e,
                      input logic [9:0] m, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        reg_addr = a; reg_rd = 1'b1; evt_pulse = m;
        @(posedge clk); #1 reg_rd = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1
        rd(2'd0, 32'h0, '0, "R1 source after reset");
        rd(2'd1, 32'h0, '0, "R1 enable after reset");
        chk_irq(1'b0, "R1");
        // R2 / R3
        pulse(10'h001);
        rd(2'd0, 32'h1, '0, "R2 bit0");
        rd(2'd0, 32'h0, '0, "R3 cleared by read");
        pulse(10'h220);
        rd(2'd0, 32'h220, '0, "R2 bits9,5");
        // R5 repeat, then R3 clears bit 31
        pulse(10'h008);
        pulse(10'h008);
        rd(2'd0, 32'h8000_0008, '0, "R5 repeat flag");
        rd(2'd0, 32'h0, '0, "R3 flag cleared");
        // R4 pulse during read
        pulse(10'h004);
        rd(2'd0, 32'h4, 10'h010, "R4 old value returned");
        rd(2'd0, 32'h10, '0, "R4 new pulse kept");
        pulse(10'h002);
        rd(2'd0, 32'h2, 10'h002, "R4 same bit during read");
        rd(2'd0, 32'h2, '0, "R4 same bit kept, R5 no flag");
        rd(2'd0, 32'h0, '0, "R3 empty");
        // R7 enable
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'h3FF, '0, "R7 enable readback");
        chk_irq(1'b0, "R6 none pending");
        pulse(10'h040);
        chk_irq(1'b1, "R6 enabled pending");
        wr(2'd1, 32'h0);
        chk_irq(1'b0, "R6 disabled");
        rd(2'd0, 32'h40, '0, "R6 source still pending");
        // R8 write to source ignored
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0, '0, "R8 source unchanged");
        rd(2'd1, 32'h0, '0, "R8 enable unchanged");
        chk_irq(1'b0, "R8");
        // R9 flag never drives irq
        wr(2'd1, 32'h8000_0100);
        rd(2'd1, 32'h100, '0, "R9 bit31 not enabled");
        pulse(10'h080);
        pulse(10'h080);
        chk_irq(1'b0, "R9 flag without enabled source");
        rd(2'd0, 32'h8000_0080, '0, "R9 source with flag");
        // R6 enable after pending
        pulse(10'h100);
        chk_irq(1'b1, "R6 bit8 enabled");
        rd(2'd0, 32'h100, '0, "R3 read bit8");
        chk_irq(1'b0, "R3 irq drops after read");
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", exp_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule